// File: doc/BRIEF.md
# Multicycle Accumulator Processor Controller

This block is the control unit and datapath of a small accumulator machine. It steps through a sequence of register transfers using five internal registers: a memory address register, a memory buffer register, an instruction register, a program counter and an accumulator. Each instruction is fetched from a single-port word memory and then decoded. If the instruction asks for it, an indirect subcycle reads a pointer word. Then comes an operand read or write, then an execute step, and control returns to fetch. Every memory transfer uses a request/ready handshake, so the memory may insert any number of wait cycles.

An instruction word is 32 bits. The opcode sits in bits [31:28], the indirect flag in bit 27 and the address field in bits [23:0]. Bits [26:24] are reserved and are written as zero. Addresses are byte addresses, and the machine fetches 4-byte instruction words. The control state and a halted flag are brought out so that exact cycle sequences can be observed.

Top module: `acc_cpu_core`

## Requirements
- R1: While rst_ni is low and after it is released, state_o is 0 (fetch-address), halted_o is 0, mem_req_o is 0, pc_o is 0 and acc_o is 0.
- R2: Each instruction is read from the byte address held in pc_o. When that read completes, pc_o advances by 4. Opcode is bits [31:28], the indirect flag is bit 27 and the address field is bits [23:0].
- R3: Opcode 0 loads the operand into the accumulator. Opcode 2 adds the operand to the accumulator and opcode 3 subtracts it. Both wrap modulo 2^32.
- R4: Opcode 1 writes the accumulator to the effective address, with mem_we_o high. It is the only instruction that writes memory.
- R5: With the indirect flag set, an extra read is made at the address field. The low 24 bits of the returned word become the effective address.
- R6: Opcode 4 loads the effective address into the PC and makes no operand access. With the indirect flag set, the PC takes the fetched pointer word.
- R7: Opcode 15 enters the halt state regardless of the indirect flag. Once halted, halted_o stays high, no memory request is issued, and pc_o and acc_o hold.
- R8: Opcodes 5 to 14 leave the accumulator and memory untouched. They make no operand access, only the pointer read when the indirect flag is set, and then fetch the next instruction.
- R9: While mem_req_o is high and mem_ready_i is low, the state, mem_addr_o, mem_we_o and mem_wdata_o all hold.
- R10: State codes are 0 fetch-address, 1 fetch-read, 2 load-IR, 3 decode, 4 indirect-read, 5 indirect-address, 6 operand-read, 7 store, 8 execute and 9 halt. Each state lasts one cycle, except that a requesting state (1, 4, 6, 7) lasts one cycle plus its wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | 24 | Byte address of the request |
| mem_wdata_o | output | 32 | Write data (accumulator) |
| mem_rdata_i | input | 32 | Read data, valid while ready is high |
| mem_ready_i | input | 1 | Completes the current request |
| state_o | output | 4 | Current control state code |
| halted_o | output | 1 | High in the halt state |
| pc_o | output | 24 | Program counter |
| acc_o | output | 32 | Accumulator |

## Verification
A directed program with zero wait cycles runs an indirect load followed by an indirect jump. Its per-cycle state trace separates the indirect, operand and execute paths, and shows that the pointer word, not the address field, steers the jump. Random programs mix all opcodes, both addressing modes, forward jumps and no-op codes under wait profiles of 0 to 5 cycles. Final accumulator, PC and memory contents expose datapath faults. The total cycle count to halt, compared against a model plus the observed waits, exposes extra or missing states and handshake slips. Idle cycles after halt show whether the halt state is truly quiet.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'd2;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'd3;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'd15;

  typedef enum logic [3:0] {
    ST_FETCH_A = 4'd0,
    ST_FETCH_M = 4'd1,
    ST_LOAD_IR = 4'd2,
    ST_DECODE  = 4'd3,
    ST_IND_M   = 4'd4,
    ST_IND_D   = 4'd5,
    ST_OPER_M  = 4'd6,
    ST_STORE_M = 4'd7,
    ST_EXEC    = 4'd8,
    ST_HALT    = 4'd9
  } state_e;

  typedef enum logic [1:0] {
    MAR_HOLD, MAR_PC, MAR_IR, MAR_MBR
  } mar_sel_e;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_KEEP
  } alu_op_e;

  typedef struct packed {
    mar_sel_e mar_sel;
    logic     mbr_load;
    logic     ir_load;
    logic     pc_inc;
    logic     pc_load;
    logic     ac_load;
    alu_op_e  alu_op;
  } ctrl_t;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_PASS: y_o = b_i;
      ALU_ADD:  y_o = a_i + b_i;
      ALU_SUB:  y_o = a_i - b_i;
      default:  y_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] ac_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic              ind_o
);
  localparam int OPC_LSB = DATA_W - OPC_W;
  localparam int IND_BIT = OPC_LSB - 1;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] mar_q, pc_q, ir_addr_q;
  logic [DATA_W-1:0] mbr_q, ac_q, alu_y;
  logic [OPC_W-1:0]  ir_opc_q;
  logic              ir_ind_q;

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (ctrl_i.alu_op),
    .a_i  (ac_q),
    .b_i  (mbr_q),
    .y_o  (alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q <= '0;
    end else begin
      unique case (ctrl_i.mar_sel)
        MAR_PC:  mar_q <= pc_q;
        MAR_IR:  mar_q <= ir_addr_q;
        MAR_MBR: mar_q <= mbr_q[ADDR_W-1:0];
        default: mar_q <= mar_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbr_q <= '0;
    end else if (ctrl_i.mbr_load) begin
      mbr_q <= mem_rdata_i;
    end
  end

  // instruction register keeps only decoded fields; reserved bits are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_opc_q  <= '0;
      ir_ind_q  <= 1'b0;
      ir_addr_q <= '0;
    end else if (ctrl_i.ir_load) begin
      ir_opc_q  <= mbr_q[DATA_W-1:OPC_LSB];
      ir_ind_q  <= mbr_q[IND_BIT];
      ir_addr_q <= mbr_q[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (ctrl_i.pc_inc) begin
      pc_q <= pc_q + PC_STEP;
    end else if (ctrl_i.pc_load) begin
      pc_q <= mar_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q <= '0;
    end else if (ctrl_i.ac_load) begin
      ac_q <= alu_y;
    end
  end

  assign mar_o    = mar_q;
  assign ac_o     = ac_q;
  assign pc_o     = pc_q;
  assign opcode_o = ir_opc_q;
  assign ind_o    = ir_ind_q;
endmodule

// File: rtl/acc_cpu_fsm.sv
module acc_cpu_fsm
  import acc_cpu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             ind_i,
  input  logic             mem_ready_i,
  output state_e           state_o,
  output ctrl_t            ctrl_o,
  output logic             mem_req_o,
  output logic             mem_we_o
);
  state_e state_q, state_d;

  // where control goes once the effective address sits in MAR
  function automatic state_e after_addr(logic [OPC_W-1:0] opc);
    unique case (opc)
      OPC_JUMP:                   return ST_EXEC;
      OPC_LOAD, OPC_ADD, OPC_SUB: return ST_OPER_M;
      OPC_STORE:                  return ST_STORE_M;
      default:                    return ST_FETCH_A;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    ctrl_o  = '0;
    unique case (state_q)
      ST_FETCH_A: begin
        ctrl_o.mar_sel = MAR_PC;
        state_d        = ST_FETCH_M;
      end
      ST_FETCH_M: begin
        if (mem_ready_i) begin
          ctrl_o.mbr_load = 1'b1;
          ctrl_o.pc_inc   = 1'b1;
          state_d         = ST_LOAD_IR;
        end
      end
      ST_LOAD_IR: begin
        ctrl_o.ir_load = 1'b1;
        state_d        = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl_o.mar_sel = MAR_IR;
        if (opcode_i == OPC_HALT) state_d = ST_HALT;
        else if (ind_i)           state_d = ST_IND_M;
        else                      state_d = after_addr(opcode_i);
      end
      ST_IND_M: begin
        if (mem_ready_i) begin
          ctrl_o.mbr_load = 1'b1;
          state_d         = ST_IND_D;
        end
      end
      ST_IND_D: begin
        ctrl_o.mar_sel = MAR_MBR;
        state_d        = after_addr(opcode_i);
      end
      ST_OPER_M: begin
        if (mem_ready_i) begin
          ctrl_o.mbr_load = 1'b1;
          state_d         = ST_EXEC;
        end
      end
      ST_STORE_M: begin
        if (mem_ready_i) state_d = ST_FETCH_A;
      end
      ST_EXEC: begin
        unique case (opcode_i)
          OPC_LOAD: begin ctrl_o.ac_load = 1'b1; ctrl_o.alu_op = ALU_PASS; end
          OPC_ADD:  begin ctrl_o.ac_load = 1'b1; ctrl_o.alu_op = ALU_ADD;  end
          OPC_SUB:  begin ctrl_o.ac_load = 1'b1; ctrl_o.alu_op = ALU_SUB;  end
          OPC_JUMP: ctrl_o.pc_load = 1'b1;
          default:  ctrl_o.alu_op = ALU_KEEP;
        endcase
        state_d = ST_FETCH_A;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH_A;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH_A;
    else         state_q <= state_d;
  end

  assign mem_req_o = (state_q == ST_FETCH_M) || (state_q == ST_IND_M) ||
                     (state_q == ST_OPER_M)  || (state_q == ST_STORE_M);
  assign mem_we_o  = (state_q == ST_STORE_M);
  assign state_o   = state_q;
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [3:0]        state_o,
  output logic              halted_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o
);
  state_e           state;
  ctrl_t            ctrl;
  logic [OPC_W-1:0] opcode;
  logic             ind;
  logic [ADDR_W-1:0] mar;

  acc_cpu_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .opcode_i    (opcode),
    .ind_i       (ind),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .ctrl_o      (ctrl),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o)
  );

  acc_cpu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .mem_rdata_i (mem_rdata_i),
    .mar_o       (mar),
    .ac_o        (acc_o),
    .pc_o        (pc_o),
    .opcode_o    (opcode),
    .ind_o       (ind)
  );

  assign mem_addr_o  = mar;
  assign mem_wdata_o = acc_o;
  assign state_o     = state;
  assign halted_o    = (state == ST_HALT);
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ready_i,
  input logic [3:0]        state_o,
  input logic              halted_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] acc_o
);
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o) && $stable(state_o)));

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_FETCH_M && mem_ready_i) |=>
      (pc_o == $past(pc_o) + ADDR_W'(DATA_W / 8)));

  a_r7_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_req_o);

  a_r7_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o) && $stable(acc_o)));

  a_r5_ind_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IND_D) |-> ($past(state_o) == ST_IND_M));

  a_r4_write_in_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> ($stable(acc_o)));

  a_r10_ir_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_LOAD_IR) |-> ($past(state_o) == ST_FETCH_M && $past(mem_ready_i)));
endmodule

bind acc_cpu_core acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .state_o     (state_o),
  .halted_o    (halted_o),
  .pc_o        (pc_o),
  .acc_o       (acc_o)
);

// File: tb/acc_cpu_core_bench.sv
module acc_cpu_core_bench;
  localparam int DW = 32;
  localparam int AW = 24;
  localparam int MW = 256;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mem_req, mem_we, mem_ready = 1'b0;
  logic [AW-1:0] mem_addr, pc;
  logic [DW-1:0] mem_wdata, mem_rdata, acc;
  logic [3:0]    state;
  logic          halted;

  logic [DW-1:0] dmem [MW];
  logic [DW-1:0] gm   [MW];
  int n_checks = 0, n_fail = 0;
  int wait_max = 0, wait_cnt = 0, waits_seen = 0;
  int trace [64];
  int trace_len = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  acc_cpu_core #(.DATA_W(DW), .ADDR_W(AW)) u_acc_cpu_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .state_o(state), .halted_o(halted),
    .pc_o(pc), .acc_o(acc)
  );

  assign mem_rdata = dmem[mem_addr[9:2]];

  // memory model: ready driven at negedge, writes committed at posedge
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && mem_req) begin
        if (wait_cnt == 0) begin
          mem_ready = 1'b1;
          wait_cnt  = (wait_max == 0) ? 0 : int'($urandom % (wait_max + 1));
        end else begin
          mem_ready = 1'b0;
          wait_cnt--;
          waits_seen++;
        end
      end else begin
        mem_ready = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      if (rst_ni && mem_req && mem_we && mem_ready) dmem[mem_addr[9:2]] <= mem_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] insn(input logic [3:0] opc, input bit ind, input logic [23:0] a);
    return {opc, ind, 3'b000, a};
  endfunction

  // instruction-level model over gm; returns cycles from reset release to halt
  task automatic model(output logic [31:0] ac, output logic [23:0] p, output int cyc);
    logic [31:0] w, opnd;
    logic [3:0]  opc;
    logic [23:0] ea;
    ac = '0; p = '0; cyc = 0;
    for (int s = 0; s < 1000; s++) begin
      w = gm[p[9:2]];
      opc = w[31:28];
      ea = w[23:0];
      p = p + 24'd4;
      cyc += 4;
      if (opc == 4'd15) return;
      if (w[27]) begin
        ea = gm[ea[9:2]][23:0];
        cyc += 2;
      end
      opnd = gm[ea[9:2]];
      unique case (opc)
        4'd0: begin ac = opnd;      cyc += 2; end
        4'd2: begin ac = ac + opnd; cyc += 2; end
        4'd3: begin ac = ac - opnd; cyc += 2; end
        4'd1: begin gm[ea[9:2]] = ac; cyc += 1; end
        4'd4: begin p = ea;         cyc += 1; end
        default: ;
      endcase
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(state == 4'd0 && !halted && !mem_req && pc == 0 && acc == 0, "R1 in reset",
          {state, 3'b0, halted, 3'b0, mem_req, pc[15:0]}, 32'h0);
  endtask

  task automatic run(input string tag, output int cyc);
    @(negedge clk_i);
    rst_ni     = 1'b1;
    waits_seen = 0;
    wait_cnt   = 0;
    cyc        = 0;
    trace_len  = 0;
    trace[trace_len++] = int'(state);
    check(state == 4'd0 && pc == 0 && acc == 0 && !halted, "R1 after release",
          {28'b0, state}, 32'h0);
    while (!halted && cyc < 5000) begin
      @(posedge clk_i);
      cyc++;
      @(negedge clk_i);
      if (trace_len < 64) trace[trace_len++] = int'(state);
    end
    check(halted, {"R7 reached halt ", tag}, {31'b0, halted}, 32'h1);
  endtask

  task automatic compare_run(input string tag);
    logic [31:0] eac;
    logic [23:0] epc;
    int ecyc, cyc, bad;
    logic [23:0] hpc;
    bit quiet;
    gm = dmem;
    model(eac, epc, ecyc);
    run(tag, cyc);
    check(acc == eac, {"R3 accumulator ", tag}, acc, eac);
    check(pc == epc, {"R6 final PC ", tag}, {8'b0, pc}, {8'b0, epc});
    check(cyc == ecyc + waits_seen, {"R10 cycles to halt ", tag}, cyc, ecyc + waits_seen);
    bad = 0;
    for (int i = 0; i < MW; i++) if (dmem[i] !== gm[i]) bad++;
    check(bad == 0, {"R4 memory image ", tag}, bad, 0);
    hpc = pc;
    quiet = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (mem_req || state != 4'd9 || pc != hpc || acc != eac) quiet = 1'b0;
    end
    check(quiet, {"R7 halt holds ", tag}, {31'b0, quiet}, 32'h1);
  endtask

  task automatic gen_prog(input int n);
    int r, tgt, di;
    logic [3:0] opc;
    bit ind;
    logic [23:0] a;
    for (int i = 0; i < MW; i++) dmem[i] = (i >= 128) ? $urandom : 32'h0;
    for (int i = 0; i < n; i++) begin
      r   = int'($urandom % 8);
      ind = ($urandom % 3) == 0;
      unique case (r)
        0, 7: opc = 4'd0;
        1:    opc = 4'd1;
        2, 6: opc = 4'd2;
        3:    opc = 4'd3;
        4:    opc = 4'd4;
        default: opc = 4'(5 + ($urandom % 10));
      endcase
      if (opc == 4'd4) begin
        tgt = i + 1 + int'($urandom % 3);
        if (tgt > n) tgt = n;
        a = 24'(tgt * 4);
      end else begin
        di = 128 + int'($urandom % 128);
        a = 24'(di * 4);
      end
      if (ind) begin
        dmem[64 + i] = {8'h00, a};
        a = 24'((64 + i) * 4);
      end
      dmem[i] = insn(opc, ind, a);
    end
    dmem[n] = insn(4'd15, 1'b0, 24'h0);
  endtask

  initial begin
    int exp_tr [20] = '{0,1,2,3,4,5,6,8, 0,1,2,3,4,5,8, 0,1,2,3,9};
    int bad, cyc;
    void'($urandom(32'd20240611));
    // directed: indirect LOAD then indirect JUMP, zero waits
    do_reset();
    for (int i = 0; i < MW; i++) dmem[i] = '0;
    dmem[0]   = insn(4'd0, 1'b1, 24'h180);
    dmem[1]   = insn(4'd4, 1'b1, 24'h184);
    dmem[2]   = insn(4'd0, 1'b0, 24'h20C);
    dmem[4]   = insn(4'd15, 1'b1, 24'h0);
    dmem[96]  = 32'hAB00_0208;
    dmem[97]  = 32'h0000_0010;
    dmem[130] = 32'h0000_1234;
    dmem[131] = 32'hDEAD_BEEF;
    wait_max = 0;
    run("directed", cyc);
    bad = 0;
    for (int i = 0; i < 20; i++) if (trace[i] != exp_tr[i]) bad++;
    check(bad == 0 && trace_len == 20, "R10 state trace", bad, 0);
    check(acc == 32'h1234, "R5 indirect operand", acc, 32'h1234);
    check(pc == 24'h14, "R6 indirect jump skips word 2", {8'b0, pc}, 32'h14);

    // directed: STORE direct, NOP with indirect, SUB wrap
    do_reset();
    for (int i = 0; i < MW; i++) dmem[i] = '0;
    dmem[0]   = insn(4'd3, 1'b0, 24'h200);
    dmem[1]   = insn(4'd1, 1'b0, 24'h204);
    dmem[2]   = insn(4'd9, 1'b1, 24'h180);
    dmem[3]   = insn(4'd15, 1'b0, 24'h0);
    dmem[96]  = 32'h0000_0200;
    dmem[128] = 32'h0000_0005;
    wait_max = 2;
    compare_run("store-nop");
    check(dmem[129] == 32'hFFFF_FFFB, "R4 store value", dmem[129], 32'hFFFF_FFFB);
    check(acc == 32'hFFFF_FFFB, "R8 no-op keeps accumulator", acc, 32'hFFFF_FFFB);

    // constrained random programs under several wait profiles
    for (int k = 0; k < 6; k++) begin
      do_reset();
      gen_prog(30);
      wait_max = (k == 0) ? 0 : (k == 3) ? 0 : k;
      compare_run($sformatf("rand%0d", k));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule